// File: doc/BRIEF.md
# Sector Erase Command Sequencer

This block is the command state machine of a flash-style memory that collects sector erase requests and then works through them on its own. The host issues a sector-erase command with the sector encoded in the top bits of the write address. That opens an acceptance window. Each further sector-erase command inside the window adds its sector to a selection mask and restarts the window. When the window runs out without a new command, the block starts the erase without further help from the host.

The erase handles the selected sectors one at a time. Each sector is first pre-programmed and then erased. A counter driven by a microsecond tick stands in for the real cell operations. While the erase runs, a suspend command freezes it and a resume command continues it. Any other command throws the job away and returns the block to read mode.

A per-sector blank mask records which sectors now read back as all ones.

Top module: `sector_erase_seq`

## Requirements
- R1: In read mode (mode code 0), a write with data 8'h30 opens the window (mode code 1) and sets the mask to the single bit of the addressed sector. The sector index is the top log2(NUM_SECT) bits of wr_addr.
- R2: Inside the window, each further 8'h30 write ORs its sector into the mask, in any order, up to all sectors. Re-queuing a sector that is already set leaves the mask unchanged.
- R3: Every accepted 8'h30 write reloads the window. The window expires on the WIN_US-th us_tick cycle that follows the last accepted write. A write in the same cycle as a tick takes precedence and the tick is not counted.
- R4: Inside the window, any write other than 8'h30 returns the block to read mode, clears the mask and erases nothing.
- R5: On window expiry the mode becomes erasing (code 2). Selected sectors are handled from the lowest index upward. For each one, cur_sector shows the sector and preprog is 1 for PRE_US ticks, then preprog is 0 for ERS_US ticks.
- R6: A sector's blank_mask bit is set when its erase phase completes. Bits of sectors that are not selected never change.
- R7: After the last selected sector completes, the block returns to read mode with the mask cleared and busy low.
- R8: While erasing, a write of 8'hB0 enters suspended mode (code 3), in which ticks have no effect. A write of 8'hD0 while suspended resumes the count exactly where it stopped.
- R9: While erasing, any write other than 8'hB0 aborts to read mode and clears the mask. Sectors already completed stay blank. While suspended, 8'hB0 is ignored, and any write other than 8'hD0 aborts in the same way.
- R10: Reset gives read mode, an empty mask, busy low and an empty blank_mask. busy is high exactly when the mode is not read.
- R11: In read mode, writes other than 8'h30 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | Qualified write strobe, one cycle per command |
| wr_addr | input | ADDR_W | Write address; top bits select the sector |
| wr_data | input | 8 | Command byte |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| sel_mask | output | NUM_SECT | Sectors selected for erase |
| busy | output | 1 | High whenever not in read mode |
| mode | output | 2 | 0 read, 1 window, 2 erasing, 3 suspended |
| blank_mask | output | NUM_SECT | Sectors whose content reads as all ones |
| cur_sector | output | log2(NUM_SECT) | Sector being worked on |
| preprog | output | 1 | High during the pre-program phase of cur_sector |

## Verification
The assertions assume that wr_stb is high for a single cycle per command and that wr_addr and wr_data are valid whenever it is high. They also assume that us_tick is a clean one-cycle pulse. The stimulus drives every input half a period away from the active edge. It issues each command as an isolated strobe cycle and raises us_tick on alternate cycles. Some commands are placed deliberately on tick cycles, to exercise the rule that a write takes precedence over a tick.

// File: rtl/ser_pkg.sv
package ser_pkg;

    typedef enum logic [1:0] {
        MODE_READ    = 2'd0,
        MODE_WINDOW  = 2'd1,
        MODE_ERASE   = 2'd2,
        MODE_SUSPEND = 2'd3
    } ser_mode_e;

    typedef enum logic [2:0] {
        CMD_NONE   = 3'd0,
        CMD_SECTOR = 3'd1,
        CMD_HOLD   = 3'd2,
        CMD_CONT   = 3'd3,
        CMD_OTHER  = 3'd4
    } ser_cmd_e;

    localparam logic [7:0] CODE_SECTOR = 8'h30;
    localparam logic [7:0] CODE_HOLD   = 8'hB0;
    localparam logic [7:0] CODE_CONT   = 8'hD0;

endpackage

// File: rtl/ser_cmd_decode.sv
module ser_cmd_decode
    import ser_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int SECT_W = 3
) (
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output ser_cmd_e          cmd,
    output logic [SECT_W-1:0] sect
);

    always_comb begin
        sect = wr_addr[ADDR_W-1 -: SECT_W];
        if (!wr_stb) begin
            cmd = CMD_NONE;
        end else begin
            unique case (wr_data)
                CODE_SECTOR: cmd = CMD_SECTOR;
                CODE_HOLD:   cmd = CMD_HOLD;
                CODE_CONT:   cmd = CMD_CONT;
                default:     cmd = CMD_OTHER;
            endcase
        end
    end

endmodule

// File: rtl/ser_win_timer.sv
module ser_win_timer #(
    parameter int WIN_US = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic clear,
    input  logic tick,
    output logic expire
);

    localparam int CNT_W = $clog2(WIN_US + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } win_state_t;

    win_state_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        expire = 1'b0;
        if (clear) begin
            s_d.cnt = '0;
        end else if (load) begin
            s_d.cnt = CNT_W'(WIN_US);
        end else if (tick && s_q.cnt != '0) begin
            s_d.cnt = s_q.cnt - 1'b1;
            expire  = (s_q.cnt == CNT_W'(1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/ser_erase_engine.sv
module ser_erase_engine #(
    parameter int NUM_SECT = 8,
    parameter int PRE_US   = 64,
    parameter int ERS_US   = 500
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [NUM_SECT-1:0]         start_mask,
    input  logic                        abort,
    input  logic                        step,
    output logic                        last_step,
    output logic [NUM_SECT-1:0]         blank_mask,
    output logic [$clog2(NUM_SECT)-1:0] cur_sector,
    output logic                        preprog
);

    localparam int SECT_W = $clog2(NUM_SECT);
    localparam int MAX_US = (PRE_US > ERS_US) ? PRE_US : ERS_US;
    localparam int STEP_W = $clog2(MAX_US + 1);

    typedef struct packed {
        logic [NUM_SECT-1:0] pend;
        logic [NUM_SECT-1:0] blank;
        logic [SECT_W-1:0]   cur;
        logic                pre;
        logic [STEP_W-1:0]   cnt;
    } eng_state_t;

    eng_state_t s_d, s_q;

    function automatic logic [SECT_W-1:0] first_set(input logic [NUM_SECT-1:0] m);
        first_set = '0;
        for (int i = NUM_SECT - 1; i >= 0; i--) begin
            if (m[i]) first_set = SECT_W'(i);
        end
    endfunction

    logic [NUM_SECT-1:0] cur_bit;
    logic [NUM_SECT-1:0] rest;
    logic                at_end;

    always_comb begin
        cur_bit   = '0;
        cur_bit[s_q.cur] = 1'b1;
        rest      = s_q.pend & ~cur_bit;
        at_end    = s_q.pre ? (s_q.cnt == STEP_W'(PRE_US - 1))
                            : (s_q.cnt == STEP_W'(ERS_US - 1));
        last_step = !s_q.pre && at_end && (rest == '0) && (s_q.pend != '0);

        s_d = s_q;
        if (start) begin
            s_d.pend = start_mask;
            s_d.cur  = first_set(start_mask);
            s_d.pre  = 1'b1;
            s_d.cnt  = '0;
        end else if (abort) begin
            s_d.pend = '0;
            s_d.pre  = 1'b0;
            s_d.cnt  = '0;
        end else if (step && s_q.pend != '0) begin
            if (!at_end) begin
                s_d.cnt = s_q.cnt + 1'b1;
            end else if (s_q.pre) begin
                s_d.pre = 1'b0;
                s_d.cnt = '0;
            end else begin
                s_d.blank = s_q.blank | cur_bit;
                s_d.pend  = rest;
                s_d.cnt   = '0;
                s_d.pre   = (rest != '0);
                if (rest != '0) s_d.cur = first_set(rest);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign blank_mask = s_q.blank;
    assign cur_sector = s_q.cur;
    assign preprog    = s_q.pre;

endmodule

// File: rtl/sector_erase_seq.sv
module sector_erase_seq
    import ser_pkg::*;
#(
    parameter int NUM_SECT = 8,
    parameter int ADDR_W   = 19,
    parameter int WIN_US   = 80,
    parameter int PRE_US   = 64,
    parameter int ERS_US   = 500,
    localparam int SECT_W  = $clog2(NUM_SECT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_stb,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [7:0]          wr_data,
    input  logic                us_tick,
    output logic [NUM_SECT-1:0] sel_mask,
    output logic                busy,
    output logic [1:0]          mode,
    output logic [NUM_SECT-1:0] blank_mask,
    output logic [SECT_W-1:0]   cur_sector,
    output logic                preprog
);

    typedef struct packed {
        ser_mode_e           mode;
        logic [NUM_SECT-1:0] mask;
    } top_state_t;

    top_state_t s_d, s_q;

    ser_cmd_e          cmd;
    logic [SECT_W-1:0] sect;
    logic              win_load, win_clear, win_expire;
    logic              eng_start, eng_abort, eng_step, eng_last;
    logic [NUM_SECT-1:0] sect_bit;

    ser_cmd_decode #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_dec (
        .wr_stb (wr_stb),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .cmd    (cmd),
        .sect   (sect)
    );

    ser_win_timer #(.WIN_US(WIN_US)) u_win (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (win_load),
        .clear (win_clear),
        .tick  (us_tick),
        .expire(win_expire)
    );

    ser_erase_engine #(.NUM_SECT(NUM_SECT), .PRE_US(PRE_US), .ERS_US(ERS_US)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (eng_start),
        .start_mask(s_q.mask),
        .abort     (eng_abort),
        .step      (eng_step),
        .last_step (eng_last),
        .blank_mask(blank_mask),
        .cur_sector(cur_sector),
        .preprog   (preprog)
    );

    always_comb begin
        s_d       = s_q;
        win_load  = 1'b0;
        win_clear = 1'b0;
        eng_start = 1'b0;
        eng_abort = 1'b0;
        eng_step  = 1'b0;
        sect_bit  = '0;
        sect_bit[sect] = 1'b1;

        unique case (s_q.mode)
            MODE_READ: begin
                if (cmd == CMD_SECTOR) begin
                    win_load = 1'b1;
                    s_d.mask = sect_bit;
                    s_d.mode = MODE_WINDOW;
                end
            end
            MODE_WINDOW: begin
                if (cmd == CMD_SECTOR) begin
                    win_load = 1'b1;
                    s_d.mask = s_q.mask | sect_bit;
                end else if (cmd != CMD_NONE) begin
                    win_clear = 1'b1;
                    s_d.mask  = '0;
                    s_d.mode  = MODE_READ;
                end else if (win_expire) begin
                    eng_start = 1'b1;
                    s_d.mode  = MODE_ERASE;
                end
            end
            MODE_ERASE: begin
                if (cmd == CMD_HOLD) begin
                    s_d.mode = MODE_SUSPEND;
                end else if (cmd != CMD_NONE) begin
                    eng_abort = 1'b1;
                    s_d.mask  = '0;
                    s_d.mode  = MODE_READ;
                end else if (us_tick) begin
                    eng_step = 1'b1;
                    if (eng_last) begin
                        s_d.mask = '0;
                        s_d.mode = MODE_READ;
                    end
                end
            end
            MODE_SUSPEND: begin
                if (cmd == CMD_CONT) begin
                    s_d.mode = MODE_ERASE;
                end else if (cmd != CMD_NONE && cmd != CMD_HOLD) begin
                    eng_abort = 1'b1;
                    s_d.mask  = '0;
                    s_d.mode  = MODE_READ;
                end
            end
            default: s_d.mode = MODE_READ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.mode <= MODE_READ;
            s_q.mask <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sel_mask = s_q.mask;
    assign mode     = s_q.mode;
    assign busy     = (s_q.mode != MODE_READ);

endmodule

// File: rtl/ser_checker.sv
module ser_checker
    import ser_pkg::*;
#(
    parameter int NUM_SECT = 8,
    parameter int ADDR_W   = 19,
    localparam int SECT_W  = $clog2(NUM_SECT)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_stb,
    input logic [ADDR_W-1:0]   wr_addr,
    input logic [7:0]          wr_data,
    input logic                us_tick,
    input logic [NUM_SECT-1:0] sel_mask,
    input logic [1:0]          mode,
    input logic [NUM_SECT-1:0] blank_mask,
    input logic [SECT_W-1:0]   cur_sector,
    input logic                preprog
);

    logic [NUM_SECT-1:0] addr_bit;
    always_comb begin
        addr_bit = '0;
        addr_bit[wr_addr[ADDR_W-1 -: SECT_W]] = 1'b1;
    end

    a_r1_open_single: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_READ && wr_stb && wr_data == CODE_SECTOR)
        |=> (mode == MODE_WINDOW && $countones(sel_mask) == 1));

    a_r2_mask_accumulate: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_WINDOW && wr_stb && wr_data == CODE_SECTOR)
        |=> (sel_mask == ($past(sel_mask) | $past(addr_bit))));

    a_r4_foreign_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_WINDOW && wr_stb && wr_data != CODE_SECTOR)
        |=> (mode == MODE_READ && sel_mask == '0));

    a_r5_start_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_ERASE && $past(mode) == MODE_WINDOW)
        |-> ($past(us_tick) && !$past(wr_stb)));

    a_r6_blank_only_selected: assert property (@(posedge clk) disable iff (!rst_n)
        ((blank_mask & ~$past(blank_mask) & ~$past(sel_mask)) == '0));

    a_r8_enter_suspend: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_ERASE && wr_stb && wr_data == CODE_HOLD)
        |=> (mode == MODE_SUSPEND));

    a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SUSPEND && $past(mode) == MODE_SUSPEND)
        |-> ($stable(cur_sector) && $stable(preprog) && $stable(blank_mask)));

    a_r9_abort_erase: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_ERASE && wr_stb && wr_data != CODE_HOLD)
        |=> (mode == MODE_READ && sel_mask == '0));

    a_r11_read_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_READ && wr_stb && wr_data != CODE_SECTOR)
        |=> (mode == MODE_READ && sel_mask == '0));

endmodule

bind sector_erase_seq ser_checker #(.NUM_SECT(NUM_SECT), .ADDR_W(ADDR_W)) u_ser_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_stb    (wr_stb),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .us_tick   (us_tick),
    .sel_mask  (sel_mask),
    .mode      (mode),
    .blank_mask(blank_mask),
    .cur_sector(cur_sector),
    .preprog   (preprog)
);

// File: tb/test_sector_erase_seq.sv
module test_sector_erase_seq;

    localparam int NS  = 8;
    localparam int AW  = 12;
    localparam int WIN = 4;
    localparam int PRE = 2;
    localparam int ERS = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_stb = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          us_tick = 1'b0;
    logic [NS-1:0] sel_mask;
    logic          busy;
    logic [1:0]    mode;
    logic [NS-1:0] blank_mask;
    logic [2:0]    cur_sector;
    logic          preprog;

    always #5 clk = ~clk;

    sector_erase_seq #(.NUM_SECT(NS), .ADDR_W(AW), .WIN_US(WIN),
                       .PRE_US(PRE), .ERS_US(ERS)) i_sector_erase_seq (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .us_tick(us_tick), .sel_mask(sel_mask),
        .busy(busy), .mode(mode), .blank_mask(blank_mask),
        .cur_sector(cur_sector), .preprog(preprog)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    bit    finished = 0;
    string req = "R10";

    // behavioural reference
    int m_mode = 0, m_mask = 0, m_win = 0, m_pend = 0, m_cur = 0;
    int m_pre = 0, m_cnt = 0, m_blank = 0;
    int tick_ph = 0;

    function automatic int lowest(int m);
        for (int i = 0; i < NS; i++) if (m[i]) return i;
        return 0;
    endfunction

    task automatic model(bit stb, logic [AW-1:0] a, logic [7:0] d, bit t);
        int s;
        s = int'(a[AW-1 -: 3]);
        case (m_mode)
            0: if (stb && d == 8'h30) begin m_mask = 1 << s; m_win = WIN; m_mode = 1; end
            1: begin
                if (stb) begin
                    if (d == 8'h30) begin m_mask |= 1 << s; m_win = WIN; end
                    else begin m_mode = 0; m_mask = 0; end
                end else if (t) begin
                    m_win--;
                    if (m_win == 0) begin
                        m_mode = 2; m_pend = m_mask; m_cur = lowest(m_mask);
                        m_pre = 1; m_cnt = 0;
                    end
                end
            end
            2: begin
                if (stb) begin
                    if (d == 8'hB0) m_mode = 3;
                    else begin m_mode = 0; m_mask = 0; end
                end else if (t) begin
                    m_cnt++;
                    if (m_pre == 1 && m_cnt == PRE) begin m_pre = 0; m_cnt = 0; end
                    else if (m_pre == 0 && m_cnt == ERS) begin
                        m_blank |= 1 << m_cur;
                        m_pend &= ~(1 << m_cur);
                        m_cnt = 0;
                        if (m_pend == 0) begin m_mode = 0; m_mask = 0; end
                        else begin m_cur = lowest(m_pend); m_pre = 1; end
                    end
                end
            end
            default: begin
                if (stb) begin
                    if (d == 8'hD0) m_mode = 2;
                    else if (d != 8'hB0) begin m_mode = 0; m_mask = 0; end
                end
            end
        endcase
    endtask

    task automatic check(string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic compare();
        check("mode", int'(mode), m_mode);
        check("sel_mask", int'(sel_mask), m_mask);
        check("busy", int'(busy), (m_mode != 0) ? 1 : 0);
        check("blank_mask", int'(blank_mask), m_blank);
        if (m_mode >= 2) begin
            check("cur_sector", int'(cur_sector), m_cur);
            check("preprog", int'(preprog), m_pre);
        end
    endtask

    // one clock: drive at negedge, model at edge, compare at next negedge
    task automatic cyc(bit stb, logic [AW-1:0] a, logic [7:0] d, bit t);
        wr_stb = stb; wr_addr = a; wr_data = d; us_tick = t;
        @(posedge clk);
        model(stb, a, d, t);
        @(negedge clk);
        compare();
    endtask

    function automatic logic [AW-1:0] sa(int s);
        return {3'(s), 9'h0A5};
    endfunction

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            cyc(0, '0, '0, tick_ph[0]);
            tick_ph++;
        end
    endtask

    task automatic cmd(logic [AW-1:0] a, logic [7:0] d);
        cyc(1, a, d, tick_ph[0]);
        tick_ph++;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        req = "R10"; compare();
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        req = "R11";
        cmd(sa(2), 8'hB0); cmd(sa(2), 8'hD0); cmd(sa(2), 8'h55);
        idle(2);

        req = "R1_R5_R6_R7";
        cmd(sa(5), 8'h30);
        idle(40);

        req = "R2_R5";
        cmd(sa(6), 8'h30); cmd(sa(1), 8'h30); cmd(sa(3), 8'h30); cmd(sa(1), 8'h30);
        idle(60);

        req = "R3";
        cmd(sa(0), 8'h30); idle(5); cmd(sa(0), 8'h30); idle(5);
        cmd(sa(7), 8'h30); idle(30);

        req = "R4";
        cmd(sa(2), 8'h30); cmd(sa(4), 8'h30); idle(3);
        cmd(sa(4), 8'h80); idle(12);

        req = "R8";
        cmd(sa(2), 8'h30); cmd(sa(4), 8'h30); idle(12);
        cmd(sa(0), 8'hB0); idle(9); cmd(sa(0), 8'hB0); idle(3);
        cmd(sa(0), 8'hD0); idle(5); cmd(sa(0), 8'hB0); idle(4);
        cmd(sa(0), 8'hD0); idle(40);

        req = "R9";
        cmd(sa(6), 8'h30); cmd(sa(3), 8'h30); idle(20);
        cmd(sa(3), 8'h30); idle(10);
        cmd(sa(5), 8'h30); idle(10);
        cmd(sa(5), 8'hB0); idle(3); cmd(sa(5), 8'h30); idle(6);
        cmd(sa(5), 8'h30); idle(10);
        cmd(sa(5), 8'hB0); idle(3); cmd(sa(5), 8'h11); idle(6);

        req = "R2";
        for (int s = NS - 1; s >= 0; s--) cmd(sa(s), 8'h30);
        idle(140);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule